// File: doc/BRIEF.md
# Dual-Mode Asynchronous Host Bus Port

This block connects an external processor to an internal register file through a non-multiplexed 8-bit data path. It has a 10-bit address and an active-low chip select. A 2-bit mode input selects one of two strobe styles. The first uses separate active-low read and write strobes. The second uses a single active-low data strobe, and a direction line decides whether the access is a read or a write.

All pad-side control lines are asynchronous to the system clock. They pass through a two-flop synchronizer. The block then turns each host access into exactly one single-cycle internal pulse, and it presents a latched address, and for writes the latched write data, alongside that pulse:

- A read pulse is issued as soon as the synchronized read condition appears.
- A write pulse is issued only after the host releases the strobe, so the write data has settled for the whole strobe.

The register file answers a read with combinational data on `reg_rdata_i`, addressed by `reg_addr_o`. The port captures that data and holds it on `rdata_o` until the next read. `rdata_oe_o` tells the pad ring when to drive the bus.

Top module: `host_bus_port`

## Requirements
- R1: With mode 00, chip select low and a low pulse on `rd_ni`, exactly one `reg_rd_o` pulse occurs, and `reg_addr_o` equals `addr_i` while it is high.
- R2: With mode 00, chip select low and a low pulse on `wr_ni`, exactly one `reg_wr_o` pulse occurs, carrying `addr_i` on `reg_addr_o` and `wdata_i` on `reg_wdata_o`.
- R3: With mode 01 and chip select low, a low pulse on `ds_ni` while `rw_i` is 1 performs one read, as in R1.
- R4: With mode 01 and chip select low, a low pulse on `ds_ni` while `rw_i` is 0 performs one write, as in R2.
- R5: While `cs_ni` is high, no strobe activity produces a `reg_rd_o` or `reg_wr_o` pulse, and `rdata_oe_o` stays 0.
- R6: Strobes that belong to the unselected mode have no effect. In mode 00 that is `ds_ni`; in mode 01 it is `rd_ni` and `wr_ni`. Neither pulses nor output enable result from them.
- R7: Mode values 10 and 11 behave exactly as mode 00.
- R8: `rdata_oe_o` is 1 exactly while chip select is low, the read condition of the current mode holds at the pads, and the write condition does not.
- R9: `rdata_o` takes the value of `reg_rdata_i` seen during a `reg_rd_o` pulse and keeps it until the next read pulse. A write does not change it.
- R10: After reset, `reg_rd_o`, `reg_wr_o`, `rdata_oe_o` and `rdata_o` are 0. Every internal pulse lasts one clock cycle, and read and write pulses are never high together.
- R11: A write pulse is not issued while the write strobe is still asserted. It follows the strobe's release within 4 clock cycles.
- R12: A read pulse is issued while the read strobe is still asserted, within 4 clock cycles of its assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Strobe style: 00 split strobes, 01 data strobe plus direction, 10/11 as 00 |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| rd_ni | input | 1 | Read strobe (mode 00), active low |
| wr_ni | input | 1 | Write strobe (mode 00), active low |
| ds_ni | input | 1 | Data strobe (mode 01), active low |
| rw_i | input | 1 | Direction (mode 01): 1 read, 0 write |
| addr_i | input | 10 | Host address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Read data towards the host |
| rdata_oe_o | output | 1 | Drive enable for the host data bus |
| reg_rd_o | output | 1 | Single-cycle internal read pulse |
| reg_wr_o | output | 1 | Single-cycle internal write pulse |
| reg_addr_o | output | 10 | Latched address for the register file |
| reg_wdata_o | output | 8 | Latched write data |
| reg_rdata_i | input | 8 | Register file read data for `reg_addr_o` |

## Verification
The bench holds a write strobe low for many cycles and expects no write pulse until it is released. A design that wrote on the asserting edge would pass stale data and fail R11. It also holds a read strobe low and expects the read pulse before release, which catches a design that waits for the deasserting edge. Strobes of the unselected mode, activity with chip select high, and the reserved mode codes are all driven. A decoder that looked at the wrong pins, ignored chip select, or treated 10/11 as the data-strobe style would then either produce pulses or drive the bus, or miss accesses. Back-to-back reads at different addresses followed by a write show whether read data is held and refreshed only by reads.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  typedef struct packed {
    logic cs_n;
    logic rd_n;
    logic wr_n;
    logic ds_n;
    logic rw;
  } pads_t;

  localparam int unsigned PADS_W = $bits(pads_t);

  // only 01 selects the data-strobe style; 10/11 fall back to split strobes
  function automatic logic strobe_style(input logic [1:0] mode);
    return mode == 2'b01;
  endfunction
endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hbp_decode.sv
module hbp_decode
  import hbp_pkg::*;
(
  input  pads_t pads_i,
  input  logic  ds_style_i,
  output logic  rd_act_o,
  output logic  wr_act_o
);
  logic sel;

  assign sel = ~pads_i.cs_n;

  always_comb begin
    if (ds_style_i) begin
      rd_act_o = sel & ~pads_i.ds_n &  pads_i.rw;
      wr_act_o = sel & ~pads_i.ds_n & ~pads_i.rw;
    end else begin
      rd_act_o = sel & ~pads_i.rd_n;
      wr_act_o = sel & ~pads_i.wr_n;
    end
  end
endmodule

// File: rtl/hbp_access.sv
module hbp_access #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_act_i,
  input  logic          wr_act_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] reg_rdata_i,
  output logic          reg_rd_o,
  output logic          reg_wr_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic [DW-1:0] rdata_o
);
  logic rd_d, wr_d;
  logic rd_rise, wr_fall;

  assign rd_rise = rd_act_i & ~rd_d;
  assign wr_fall = ~wr_act_i & wr_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_d        <= 1'b0;
      wr_d        <= 1'b0;
      reg_rd_o    <= 1'b0;
      reg_wr_o    <= 1'b0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
      rdata_o     <= '0;
    end else begin
      rd_d     <= rd_act_i;
      wr_d     <= wr_act_i;
      reg_rd_o <= rd_rise;
      reg_wr_o <= wr_fall;
      // pads are stable once the synchronized strobe is seen
      if (rd_rise) begin
        reg_addr_o <= addr_i;
      end else if (wr_act_i) begin
        reg_addr_o  <= addr_i;
        reg_wdata_o <= wdata_i;
      end
      if (reg_rd_o) rdata_o <= reg_rdata_i;
    end
  end
endmodule

// File: rtl/host_bus_port.sv
module host_bus_port
  import hbp_pkg::*;
#(
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              ds_ni,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  output logic              reg_rd_o,
  output logic              reg_wr_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam logic [PADS_W-1:0] PADS_IDLE = '1;

  pads_t pads_raw, pads_s;
  logic [PADS_W-1:0] sync_q;
  logic ds_style;
  logic pad_rd, pad_wr, s_rd, s_wr;

  assign ds_style = strobe_style(mode_i);

  always_comb begin
    pads_raw.cs_n = cs_ni;
    pads_raw.rd_n = rd_ni;
    pads_raw.wr_n = wr_ni;
    pads_raw.ds_n = ds_ni;
    pads_raw.rw   = rw_i;
  end

  hbp_sync #(
    .WIDTH   (PADS_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PADS_IDLE)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pads_raw),
    .q_o    (sync_q)
  );

  assign pads_s = pads_t'(sync_q);

  // pad-level decode drives the bus enable without clock latency
  hbp_decode u_dec_pad (
    .pads_i     (pads_raw),
    .ds_style_i (ds_style),
    .rd_act_o   (pad_rd),
    .wr_act_o   (pad_wr)
  );

  hbp_decode u_dec_sync (
    .pads_i     (pads_s),
    .ds_style_i (ds_style),
    .rd_act_o   (s_rd),
    .wr_act_o   (s_wr)
  );

  assign rdata_oe_o = pad_rd & ~pad_wr;

  hbp_access #(
    .AW (ADDR_W),
    .DW (DATA_W)
  ) u_access (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_act_i    (s_rd),
    .wr_act_i    (s_wr),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .reg_rdata_i (reg_rdata_i),
    .reg_rd_o    (reg_rd_o),
    .reg_wr_o    (reg_wr_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .rdata_o     (rdata_o)
  );
endmodule

// File: rtl/host_bus_port_checker.sv
module host_bus_port_checker #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_ni,
  input logic          rdata_oe_o,
  input logic          reg_rd_o,
  input logic          reg_wr_o,
  input logic [DW-1:0] rdata_o
);
  logic [2:0] cs_hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cs_hi_cnt <= '0;
    else if (cs_ni == 1'b0) cs_hi_cnt <= '0;
    else if (cs_hi_cnt != 3'd4) cs_hi_cnt <= cs_hi_cnt + 3'd1;
  end

  a_r10_rd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> !reg_rd_o);

  a_r10_wr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);

  a_r10_not_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_rd_o && reg_wr_o));

  a_r8_oe_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_oe_o |-> !cs_ni);

  a_r5_idle_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_hi_cnt == 3'd4) |-> (!reg_rd_o && !reg_wr_o));

  a_r9_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(reg_rd_o) |-> $stable(rdata_o));
endmodule

bind host_bus_port host_bus_port_checker #(.DW(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .rdata_oe_o (rdata_oe_o),
  .reg_rd_o   (reg_rd_o),
  .reg_wr_o   (reg_wr_o),
  .rdata_o    (rdata_o)
);

// File: tb/host_bus_port_bench.sv
`timescale 1ns/1ps
module host_bus_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ds_n = 1'b1, rw = 1'b1;
  logic [9:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, reg_wdata, reg_rdata;
  logic [9:0] reg_addr;
  logic oe, reg_rd, reg_wr;

  int tests = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0, width_err = 0;
  logic [9:0] rd_addr_seen, wr_addr_seen;
  logic [7:0] wr_data_seen;
  logic rd_prev = 1'b0, wr_prev = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] model(input logic [9:0] a);
    return a[7:0] ^ {a[9:8], 6'h1A};
  endfunction
  assign reg_rdata = model(reg_addr);

  host_bus_port u_host_bus_port (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .cs_ni(cs_n), .rd_ni(rd_n),
    .wr_ni(wr_n), .ds_ni(ds_n), .rw_i(rw), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rdata_oe_o(oe), .reg_rd_o(reg_rd), .reg_wr_o(reg_wr),
    .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata)
  );

  always @(posedge clk) begin
    if (reg_rd) begin rd_cnt++; rd_addr_seen = reg_addr; end
    if (reg_wr) begin wr_cnt++; wr_addr_seen = reg_addr; wr_data_seen = reg_wdata; end
    if ((reg_rd && rd_prev) || (reg_wr && wr_prev) || (reg_rd && reg_wr)) width_err++;
    rd_prev = reg_rd;
    wr_prev = reg_wr;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // split-strobe write; mode chosen by caller
  task automatic split_write(input string req, input logic [9:0] a, input logic [7:0] d);
    int w0 = wr_cnt;
    addr = a; wdata = d; cs_n = 0; cyc(1);
    wr_n = 0; cyc(8);
    chk({req, "/R11 no early write"}, wr_cnt, w0);
    chk({req, "/R8 no oe on write"}, oe, 0);
    wr_n = 1; cyc(6);
    cs_n = 1; cyc(2);
    chk({req, " write count"}, wr_cnt, w0 + 1);
    chk({req, " write addr"}, wr_addr_seen, a);
    chk({req, " write data"}, wr_data_seen, d);
  endtask

  task automatic split_read(input string req, input logic [9:0] a);
    int r0 = rd_cnt;
    addr = a; cs_n = 0; cyc(1);
    rd_n = 0; cyc(1);
    chk({req, "/R8 oe on read"}, oe, 1);
    cyc(5);
    chk({req, "/R12 read before release"}, rd_cnt, r0 + 1);
    chk({req, " read addr"}, rd_addr_seen, a);
    chk({req, "/R9 rdata"}, rdata, model(a));
    rd_n = 1; #0.1;
    chk({req, "/R8 oe off"}, oe, 0);
    cyc(6); cs_n = 1; cyc(2);
    chk({req, " single read"}, rd_cnt, r0 + 1);
  endtask

  task automatic t_reset;
    chk("R10 reg_rd", reg_rd, 0);
    chk("R10 reg_wr", reg_wr, 0);
    chk("R10 oe", oe, 0);
    chk("R10 rdata", rdata, 0);
  endtask

  task automatic t_m00;
    mode = 2'b00;
    split_write("R2", 10'h2A5, 8'hC3);
    split_read("R1", 10'h13C);
  endtask

  task automatic t_m01;
    int w0 = wr_cnt, r0 = rd_cnt;
    mode = 2'b01;
    addr = 10'h3F0; wdata = 8'h96; rw = 0; cs_n = 0; cyc(1);
    ds_n = 0; cyc(8);
    chk("R4/R11 no early write", wr_cnt, w0);
    ds_n = 1; cyc(6);
    chk("R4 write count", wr_cnt, w0 + 1);
    chk("R4 write addr", wr_addr_seen, 10'h3F0);
    chk("R4 write data", wr_data_seen, 8'h96);
    rw = 1; addr = 10'h055; cyc(1);
    ds_n = 0; cyc(1);
    chk("R3/R8 oe", oe, 1);
    cyc(5);
    chk("R3 read count", rd_cnt, r0 + 1);
    chk("R3 read addr", rd_addr_seen, 10'h055);
    chk("R3/R9 rdata", rdata, model(10'h055));
    ds_n = 1; cyc(6); cs_n = 1; cyc(2);
    chk("R3 no extra write", wr_cnt, w0 + 1);
    mode = 2'b00;
  endtask

  task automatic t_cs_high;
    int w0 = wr_cnt, r0 = rd_cnt;
    logic oe_seen = 0;
    mode = 2'b00; cs_n = 1; addr = 10'h111;
    rd_n = 0; #0.1 oe_seen |= oe; cyc(6); rd_n = 1; cyc(2);
    wr_n = 0; cyc(6); wr_n = 1; cyc(2);
    mode = 2'b01; rw = 1; ds_n = 0; #0.1 oe_seen |= oe; cyc(6); ds_n = 1; cyc(6);
    mode = 2'b00;
    chk("R5 no read", rd_cnt, r0);
    chk("R5 no write", wr_cnt, w0);
    chk("R5 no oe", oe_seen, 0);
  endtask

  task automatic t_foreign;
    int w0 = wr_cnt, r0 = rd_cnt;
    logic [7:0] hold = rdata;
    logic oe_seen = 0;
    mode = 2'b00; cs_n = 0; addr = 10'h222;
    rw = 1; ds_n = 0; #0.1 oe_seen |= oe; cyc(6); ds_n = 1; cyc(2);
    rw = 0; ds_n = 0; cyc(6); ds_n = 1; cyc(2); rw = 1;
    cs_n = 1; cyc(2);
    mode = 2'b01; cs_n = 0;
    rd_n = 0; #0.1 oe_seen |= oe; cyc(6); rd_n = 1; cyc(2);
    wr_n = 0; cyc(6); wr_n = 1; cyc(6);
    cs_n = 1; cyc(6); mode = 2'b00;
    chk("R6 no read", rd_cnt, r0);
    chk("R6 no write", wr_cnt, w0);
    chk("R6 no oe", oe_seen, 0);
    chk("R6 rdata kept", rdata, hold);
  endtask

  task automatic t_reserved;
    int r0;
    mode = 2'b10;
    split_write("R7 mode10", 10'h0C3, 8'h5E);
    mode = 2'b11;
    split_read("R7 mode11", 10'h301);
    r0 = rd_cnt;
    cs_n = 0; rw = 1; ds_n = 0; #0.1;
    chk("R7 ds ignored oe", oe, 0);
    cyc(6); ds_n = 1; cs_n = 1; cyc(6);
    chk("R7 ds ignored", rd_cnt, r0);
    mode = 2'b00;
  endtask

  task automatic t_hold;
    mode = 2'b00;
    split_read("R9 first", 10'h0AA);
    split_read("R9 second", 10'h255);
    split_write("R9 write", 10'h0AA, 8'h00);
    chk("R9 rdata after write", rdata, model(10'h255));
    cs_n = 0; rd_n = 0; wr_n = 0; #0.1;
    chk("R8 both strobes no oe", oe, 0);
    rd_n = 1; wr_n = 1; cs_n = 1; cyc(8);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1; cyc(3);
    t_reset();
    t_m00();
    t_m01();
    t_cs_high();
    t_foreign();
    t_reserved();
    t_hold();
    chk("R10 pulse width", width_err, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule